// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between a processor write bus and the control side of an on-chip flash array. It turns bus writes into array operations. A one-cycle command selects read-array mode, read-status mode or a status clear. Program, block erase, erase of all unlocked blocks and lock-bit program each take two bus writes. The sequencer checks each two-write sequence and applies per-block lock protection before it issues a start to the array engine. It then waits for the engine's done pulse and its pass/fail flag.

The outcome is kept in a sticky two-bit error field. `11` means a malformed command sequence, `10` an erase failure and `01` a program failure. A ready bit is low while the engine works. A lock-disable input lets writes reach locked blocks. The lock table holds one bit per block. A successful lock-bit program sets the bit and a successful erase clears it.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset the error field is `00`, ready is 1, read mode is 1 (array), all lock bits are 0 and no start pulse is present.
- R2: A first write whose low byte is none of 40h, 20h, A7h, 77h, FFh, 50h or 70h sets the error field to `11` and selects read mode 0 (status), with no start.
- R3: For two-write commands 20h (block erase), A7h (erase all unlocked) and 77h (lock-bit program), a second write with low byte D0h issues a one-cycle start in the cycle after that write. Any low byte other than D0h or FFh issues no start and ORs `11` into the error field.
- R4: Low byte FFh in the second write of 20h, A7h or 77h discards the command, sets read mode to 1 and changes neither the error field nor the engine.
- R5: A block erase to a block whose lock bit is 1, with lock-disable 0, ORs `10` into the error field and issues no start. With lock-disable 1 it starts.
- R6: A program (40h, with any second-write data) to a locked block with lock-disable 0 ORs `01` into the error field and issues no start. With lock-disable 1 it starts.
- R7: When the engine reports failure on done, a block erase or erase-all ORs `10` into the error field, and a program or lock-bit program ORs `01`.
- R8: Error bits only accumulate, by OR, and are cleared only by the 50h command.
- R9: Ready goes low together with the start pulse and returns high in the cycle after done. Bus writes received while ready is low are ignored.
- R10: The erase-all block mask is the complement of the lock bits when lock-disable is 0, and all ones when it is 1.
- R11: A passing lock-bit program sets the target block's lock bit. A passing block erase clears it. A passing erase-all clears the lock bits of every masked block.
- R12: Command FFh sets read mode to 1 and 70h sets it to 0. Every start sets it to 0.

Engine operation codes are 0 for program, 1 for block erase, 2 for erase all and 3 for lock-bit program. The target block is the top log2(blocks) bits of the second write's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address; top bits select the block |
| bus_wdata | input | DATA_W | Bus write data; low byte is the command or confirm code |
| lock_off | input | 1 | 1 lets operations reach locked blocks |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure flag, valid with eng_done |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_op | output | 2 | Operation code for the engine |
| eng_addr | output | ADDR_W | Target address of the operation |
| eng_data | output | DATA_W | Program data (second write) |
| eng_mask | output | NUM_BLK | Blocks to erase for erase-all |
| stat_err | output | 2 | Sticky error code |
| stat_ready | output | 1 | 1 when no array operation is running |
| read_mode | output | 1 | 1 array read, 0 status read |
| lock_bits | output | NUM_BLK | Per-block lock bits |

## Verification
The bench builds the block with eight blocks, a 12-bit address and 16-bit data. With that configuration it can sweep all 256 first-write codes and, for each of the three confirmed commands, all 256 second-write codes. The sweep spreads the confirm writes across every block index. Alternating lock patterns and both lock-disable settings cover every block against locked and unlocked protection. A reference model in the bench tracks the expected error code, read mode and lock table.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_ERALL = 2'd2,
    OP_LOCK  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    K_TWO, K_READ, K_CLR, K_STAT, K_BAD
  } kind_e;

  localparam logic [1:0] ERR_PROG  = 2'b01;
  localparam logic [1:0] ERR_ERASE = 2'b10;
  localparam logic [1:0] ERR_SEQ   = 2'b11;

  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_ERALL = 8'hA7;
  localparam logic [7:0] C_LOCK  = 8'h77;
  localparam logic [7:0] C_READ  = 8'hFF;
  localparam logic [7:0] C_CLR   = 8'h50;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_GO    = 8'hD0;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import flash_seq_pkg::*;
(
  input  logic [7:0] code,
  output kind_e      kind,
  output op_e        op,
  output logic       cfm_go,
  output logic       cfm_abort
);
  always_comb begin
    kind = K_BAD;
    op   = OP_PROG;
    case (code)
      C_PROG:  begin kind = K_TWO; op = OP_PROG;  end
      C_ERASE: begin kind = K_TWO; op = OP_ERASE; end
      C_ERALL: begin kind = K_TWO; op = OP_ERALL; end
      C_LOCK:  begin kind = K_TWO; op = OP_LOCK;  end
      C_READ:  kind = K_READ;
      C_CLR:   kind = K_CLR;
      C_STAT:  kind = K_STAT;
      default: kind = K_BAD;
    endcase
  end

  assign cfm_go    = (code == C_GO);
  assign cfm_abort = (code == C_READ);
endmodule

// File: rtl/fcs_status.sv
module fcs_status (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] set_bits,
  input  logic       clr,
  input  logic       busy_set,
  input  logic       busy_clr,
  output logic [1:0] err,
  output logic       ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= '0;
      ready <= 1'b1;
    end else begin
      if (clr) err <= '0;
      else     err <= err | set_bits;
      if (busy_set)      ready <= 1'b0;
      else if (busy_clr) ready <= 1'b1;
    end
  end

  // R8: bits never fall without a clear request
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err & $past(err)) == $past(err)));
endmodule

// File: rtl/fcs_locks.sv
module fcs_locks #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic               mclr_en,
  input  logic [BLK_W-1:0]   idx,
  input  logic [NUM_BLK-1:0] mask,
  output logic [NUM_BLK-1:0] bits
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= 1'b0;
      else if (set_en && idx == BLK_W'(i))       q <= 1'b1;
      else if ((clr_en && idx == BLK_W'(i)) ||
               (mclr_en && mask[i]))             q <= 1'b0;
    end
    assign bits[i] = q;
  end

  a_r11_lock_set: assert property (@(posedge clk) disable iff (rst)
    set_en |=> bits[idx]);
  a_r11_lock_clr: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !bits[idx]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               lock_off,
  input  logic               eng_done,
  input  logic               eng_fail,
  output logic               eng_start,
  output logic [1:0]         eng_op,
  output logic [ADDR_W-1:0]  eng_addr,
  output logic [DATA_W-1:0]  eng_data,
  output logic [NUM_BLK-1:0] eng_mask,
  output logic [1:0]         stat_err,
  output logic               stat_ready,
  output logic               read_mode,
  output logic [NUM_BLK-1:0] lock_bits
);
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CFM, S_BUSY} st_e;

  st_e   state;
  op_e   pend_op, dec_op;
  kind_e kind;
  logic  cfm_go, cfm_abort;
  logic [BLK_W-1:0]   bus_blk, eng_blk;
  logic [NUM_BLK-1:0] lock_eff;
  logic               bus_locked;
  logic [1:0]         err_set;
  logic clr_req, go, done_ack, lk_set, lk_clr, lk_mclr;

  assign bus_blk    = bus_addr[ADDR_W-1 -: BLK_W];
  assign eng_blk    = eng_addr[ADDR_W-1 -: BLK_W];
  assign lock_eff   = lock_off ? '0 : lock_bits;
  assign bus_locked = lock_eff[bus_blk];

  fcs_decode u_dec (
    .code(bus_wdata[7:0]), .kind(kind), .op(dec_op),
    .cfm_go(cfm_go), .cfm_abort(cfm_abort)
  );

  always_comb begin
    err_set  = '0;
    clr_req  = 1'b0;
    go       = 1'b0;
    done_ack = 1'b0;
    lk_set   = 1'b0;
    lk_clr   = 1'b0;
    lk_mclr  = 1'b0;
    case (state)
      S_IDLE: if (bus_we) begin
        if (kind == K_BAD) err_set = ERR_SEQ;
        if (kind == K_CLR) clr_req = 1'b1;
      end
      S_CFM: if (bus_we) begin
        if (pend_op == OP_PROG) begin
          if (bus_locked) err_set = ERR_PROG;
          else            go = 1'b1;
        end else if (!cfm_abort) begin
          if (!cfm_go)                                err_set = ERR_SEQ;
          else if (pend_op == OP_ERASE && bus_locked) err_set = ERR_ERASE;
          else                                        go = 1'b1;
        end
      end
      S_BUSY: if (eng_done) begin
        done_ack = 1'b1;
        if (eng_fail)
          err_set = (eng_op == OP_ERASE || eng_op == OP_ERALL) ? ERR_ERASE : ERR_PROG;
        else begin
          lk_set  = (eng_op == OP_LOCK);
          lk_clr  = (eng_op == OP_ERASE);
          lk_mclr = (eng_op == OP_ERALL);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pend_op   <= OP_PROG;
      read_mode <= 1'b1;
      eng_start <= 1'b0;
      eng_op    <= '0;
      eng_addr  <= '0;
      eng_data  <= '0;
      eng_mask  <= '0;
    end else begin
      eng_start <= 1'b0;
      case (state)
        S_IDLE: if (bus_we) begin
          case (kind)
            K_TWO:  begin state <= S_CFM; pend_op <= dec_op; end
            K_READ: read_mode <= 1'b1;
            K_STAT, K_BAD: read_mode <= 1'b0;
            default: ;
          endcase
        end
        S_CFM: if (bus_we) begin
          if (go) begin
            state     <= S_BUSY;
            eng_start <= 1'b1;
            eng_op    <= pend_op;
            eng_addr  <= bus_addr;
            eng_data  <= bus_wdata;
            eng_mask  <= (pend_op == OP_ERALL) ? ({NUM_BLK{lock_off}} | ~lock_bits) : '0;
            read_mode <= 1'b0;
          end else begin
            state     <= S_IDLE;
            read_mode <= (pend_op != OP_PROG) && cfm_abort;
          end
        end
        S_BUSY: if (eng_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  fcs_status u_stat (
    .clk(clk), .rst(rst), .set_bits(err_set), .clr(clr_req),
    .busy_set(go), .busy_clr(done_ack), .err(stat_err), .ready(stat_ready)
  );

  fcs_locks #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_locks (
    .clk(clk), .rst(rst), .set_en(lk_set), .clr_en(lk_clr), .mclr_en(lk_mclr),
    .idx(eng_blk), .mask(eng_mask), .bits(lock_bits)
  );

  a_r9_start_pulse: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  a_r9_start_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !stat_ready);
  a_r3_start_needs_write: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(bus_we));
  a_r10_mask_skips_locked: assert property (@(posedge clk) disable iff (rst)
    (eng_start && eng_op == OP_ERALL) |-> ((eng_mask & $past(lock_eff)) == '0));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int NB = 8;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic lock_off = 1'b0;
  logic eng_done = 1'b0;
  logic eng_fail = 1'b0;
  logic eng_start, stat_ready, read_mode;
  logic [1:0] eng_op, stat_err;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_data;
  logic [NB-1:0] eng_mask, lock_bits;

  always #2 clk = ~clk;

  flash_cmd_seq #(.NUM_BLK(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .lock_off(lock_off), .eng_done(eng_done), .eng_fail(eng_fail),
    .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
    .eng_mask(eng_mask), .stat_err(stat_err), .stat_ready(stat_ready),
    .read_mode(read_mode), .lock_bits(lock_bits)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0]    exp_err  = '0;
  logic [NB-1:0] exp_lock = '0;
  logic          exp_rm   = 1'b1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] baddr(int b);
    return AW'(b) << (AW - BW);
  endfunction

  task automatic bwr(input logic [AW-1:0] a, input logic [7:0] c);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = {8'hA5, c};
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic finish_op(input bit f);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = f;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic clr_status();
    bwr('0, 8'h50);
    exp_err = '0;
    chk("R8 clear", stat_err, 0);
  endtask

  task automatic do_two(input logic [7:0] cmd, input int blk, input logic [7:0] cfm,
                        input bit f, input bit lo);
    bit locked, go;
    string tag;
    logic [NB-1:0] mexp;
    logic [1:0] opx;
    lock_off = lo;
    locked = exp_lock[blk] && !lo;
    mexp = lo ? '1 : ~exp_lock;
    opx = (cmd == 8'h40) ? 2'd0 : (cmd == 8'h20) ? 2'd1 : (cmd == 8'hA7) ? 2'd2 : 2'd3;
    bwr(baddr(blk), cmd);
    chk("R3 first write no start", eng_start, 0);
    bwr(baddr(blk), cfm);
    go = 1'b0;
    if (cmd == 8'h40) begin
      tag = "R6";
      if (locked) begin exp_err |= 2'b01; exp_rm = 1'b0; end
      else go = 1'b1;
    end else if (cfm == 8'hFF) begin
      tag = "R4"; exp_rm = 1'b1;
    end else if (cfm != 8'hD0) begin
      tag = "R3"; exp_err |= 2'b11; exp_rm = 1'b0;
    end else if (cmd == 8'h20 && locked) begin
      tag = "R5"; exp_err |= 2'b10; exp_rm = 1'b0;
    end else begin
      tag = "R3"; go = 1'b1;
    end
    if (go) exp_rm = 1'b0;
    chk({tag, " start"}, eng_start, go);
    chk({tag, " err"}, stat_err, exp_err);
    chk("R12 read mode", read_mode, exp_rm);
    if (go) begin
      chk("R3 op code", eng_op, opx);
      chk("R9 busy", stat_ready, 0);
      if (cmd == 8'hA7) chk("R10 mask", eng_mask, mexp);
      bwr('0, 8'h50);
      chk("R9 ignored clear", stat_err, exp_err);
      bwr('0, 8'hFF);
      chk("R9 ignored read", read_mode, 0);
      finish_op(f);
      if (f) exp_err |= (cmd == 8'h20 || cmd == 8'hA7) ? 2'b10 : 2'b01;
      else if (cmd == 8'h77) exp_lock[blk] = 1'b1;
      else if (cmd == 8'h20) exp_lock[blk] = 1'b0;
      else if (cmd == 8'hA7) exp_lock &= ~mexp;
      chk("R7 err after done", stat_err, exp_err);
      chk("R9 ready", stat_ready, 1);
      chk("R11 locks", lock_bits, exp_lock);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 err", stat_err, 0);
    chk("R1 ready", stat_ready, 1);
    chk("R1 read mode", read_mode, 1);
    chk("R1 locks", lock_bits, 0);
    chk("R1 start", eng_start, 0);

    // sweep every first-write code
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      cc = 8'(c);
      if (cc == 8'h40) do_two(cc, 1, 8'h3C, 1'b0, 1'b0);
      else if (cc == 8'h20 || cc == 8'hA7 || cc == 8'h77) do_two(cc, 1, 8'hFF, 1'b0, 1'b0);
      else begin
        bwr(baddr(1), cc);
        if (cc == 8'hFF) exp_rm = 1'b1;
        else if (cc == 8'h70) exp_rm = 1'b0;
        else if (cc == 8'h50) exp_err = '0;
        else begin exp_err |= 2'b11; exp_rm = 1'b0; end
        chk("R2 err", stat_err, exp_err);
        chk("R12 mode", read_mode, exp_rm);
        chk("R2 no start", eng_start, 0);
      end
      if (exp_err != 0) clr_status();
    end

    // sweep every confirm code for the three confirmed commands
    for (int k = 0; k < 3; k++) begin
      logic [7:0] cmd;
      cmd = (k == 0) ? 8'h20 : (k == 1) ? 8'hA7 : 8'h77;
      for (int v = 0; v < 256; v++) begin
        do_two(cmd, v % NB, 8'(v), 1'b0, 1'b0);
        if (exp_err != 0) clr_status();
      end
    end

    // unlock all, then lock even blocks
    do_two(8'hA7, 0, 8'hD0, 1'b0, 1'b1);
    for (int b = 0; b < NB; b += 2) do_two(8'h77, b, 8'hD0, 1'b0, 1'b0);
    for (int b = 0; b < NB; b++) begin
      do_two(8'h20, b, 8'hD0, 1'b0, 1'b0);
      if (exp_err != 0) clr_status();
    end
    for (int b = 0; b < NB; b++) begin
      do_two(8'h40, b, 8'(b), 1'b0, 1'b0);
      if (exp_err != 0) clr_status();
    end
    // odd blocks erased above are unlocked; erase-all skips the even ones
    do_two(8'hA7, 0, 8'hD0, 1'b0, 1'b0);
    chk("R10 locks kept", lock_bits, 8'h55);
    // lock-disable lets locked blocks through
    do_two(8'h40, 0, 8'h11, 1'b0, 1'b1);
    do_two(8'h20, 2, 8'hD0, 1'b0, 1'b1);
    do_two(8'hA7, 0, 8'hD0, 1'b0, 1'b1);
    chk("R11 all cleared", lock_bits, 0);

    // engine failures and accumulation
    do_two(8'h20, 1, 8'hD0, 1'b1, 1'b0);
    do_two(8'h40, 1, 8'h22, 1'b1, 1'b0);
    chk("R8 accumulated", stat_err, 3);
    clr_status();
    do_two(8'hA7, 0, 8'hD0, 1'b1, 1'b0);
    clr_status();
    do_two(8'h77, 3, 8'hD0, 1'b1, 1'b0);
    chk("R7 lock unchanged on fail", lock_bits, 0);
    clr_status();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule